// File: doc/BRIEF.md
# Multiprocessor Miss Classification Engine

This block watches a trace of shared-memory references, one per cycle, and sorts the cache misses that a write-invalidate system with infinite caches would take. Each reference names a processor, a tracked block, a word inside that block and whether it is a load or a store. The block keeps flags for every processor and block: whether the block is currently held, whether the current lifetime has delivered a value, and whether an earlier lifetime has already ended. It also keeps, for every word and processor, a flag meaning "another processor wrote this word since this processor last picked up new data".

A miss is judged when its lifetime ends. That happens when another processor stores into the block, or during an end-of-trace sweep. A lifetime that a processor opens on a block for the first time counts as cold. A later lifetime counts as pure true sharing only if the processor touched a word written by someone else during that lifetime. Otherwise it counts as pure false sharing. This is judged from every access made while the block stayed valid, not just from the word that caused the miss. The three totals are saturating counters on the output ports.

Top module: `miss_classifier`

## Requirements
- R1: After synchronous reset all three counts are zero, every flag is clear and `ref_ready` is 1.
- R2: An accepted load never changes any count. An access by a processor that does not hold the block opens a new lifetime and clears that lifetime's delivered flag.
- R3: An accepted store by processor p ends, in that cycle, the lifetime of every other processor holding the block. Each ended lifetime adds exactly one to one count, so a store can add up to NPROC-1 in one cycle. The store also marks the stored word as changed for each of those processors.
- R4: An ended lifetime counts as cold if its processor never had an earlier lifetime on that block. If there was an earlier lifetime, it counts as true sharing when its delivered flag is set, and as false sharing when the flag is clear.
- R5: When processor p accesses a word that is marked as changed for p, the delivered flag of p's current lifetime is set. All of p's changed marks on that block are then cleared. Marks on other words stay set until such an access happens.
- R6: A store counts as an access for R5, exactly as a load does.
- R7: `end_trace` sampled high while `ref_ready` is 1 starts a sweep. During the sweep, `ref_ready` is 0 for exactly NPROC*NBLK cycles, starting the next cycle. The sweep ends every lifetime still open and classifies each one by R4.
- R8: A reference offered while `ref_ready` is 0 is ignored. It changes no flag and no count.
- R9: With SATURATE=1, a count that reaches all ones stays there while further lifetimes of its kind end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | A reference is offered |
| ref_ready | output | 1 | Reference accepted this cycle when valid; low during a sweep |
| ref_pid | input | $clog2(NPROC) | Issuing processor |
| ref_blk | input | $clog2(NBLK) | Tracked block index |
| ref_word | input | $clog2(NWORD) | Word inside the block |
| ref_store | input | 1 | 1 = store, 0 = load |
| end_trace | input | 1 | Pulse that starts the closing sweep |
| cold_count | output | CNT_W | Cold lifetimes counted |
| true_count | output | CNT_W | Pure true sharing lifetimes counted |
| false_count | output | CNT_W | Pure false sharing lifetimes counted |

## Verification
The bench builds the block with four processors, four blocks and four words. This makes a single store able to end three lifetimes at once, and makes the sweep 16 cycles long. Counters are reduced to 4 bits, so a few dozen invalidations are enough to reach the saturation ceiling and keep going past it. Seeded random traffic is limited to two blocks, so invalidations and revisits to the same block happen often.

// File: rtl/mcls_pkg.sv
package mcls_pkg;

   typedef enum logic [1:0] {
      KIND_COLD  = 2'd0,
      KIND_TRUE  = 2'd1,
      KIND_FALSE = 2'd2
   } miss_kind_e;

   // Judge one finished lifetime from its two per-pair flags.
   function automatic miss_kind_e judge(input logic had_prior, input logic delivered);
      if (!had_prior)
         return KIND_COLD;
      else if (delivered)
         return KIND_TRUE;
      else
         return KIND_FALSE;
   endfunction

endpackage

// File: rtl/mcls_flag_update.sv
module mcls_flag_update
   import mcls_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 4,
   parameter int NWORD = 4,
   parameter int INC_W = 3,
   localparam int PID_W = $clog2(NPROC),
   localparam int BLK_W = $clog2(NBLK),
   localparam int WRD_W = $clog2(NWORD)
) (
   input  logic                                    acc_fire,
   input  logic [PID_W-1:0]                        acc_pid,
   input  logic [BLK_W-1:0]                        acc_blk,
   input  logic [WRD_W-1:0]                        acc_word,
   input  logic                                    acc_store,
   input  logic                                    sw_fire,
   input  logic [PID_W-1:0]                        sw_pid,
   input  logic [BLK_W-1:0]                        sw_blk,
   input  logic [NBLK-1:0][NPROC-1:0]              held_q,
   input  logic [NBLK-1:0][NPROC-1:0]              dlvr_q,
   input  logic [NBLK-1:0][NPROC-1:0]              prior_q,
   input  logic [NBLK-1:0][NWORD-1:0][NPROC-1:0]   chg_q,
   output logic [NBLK-1:0][NPROC-1:0]              held_d,
   output logic [NBLK-1:0][NPROC-1:0]              dlvr_d,
   output logic [NBLK-1:0][NPROC-1:0]              prior_d,
   output logic [NBLK-1:0][NWORD-1:0][NPROC-1:0]   chg_d,
   output logic [2:0][INC_W-1:0]                   bump
);

   miss_kind_e kind;

   always_comb begin
      held_d  = held_q;
      dlvr_d  = dlvr_q;
      prior_d = prior_q;
      chg_d   = chg_q;
      bump    = '0;
      kind    = KIND_COLD;
      if (acc_fire) begin
         // access by a non-holder opens a new lifetime
         if (!held_q[acc_blk][acc_pid]) begin
            held_d[acc_blk][acc_pid] = 1'b1;
            dlvr_d[acc_blk][acc_pid] = 1'b0;
         end
         // touching a word changed by someone else delivers new data
         if (chg_q[acc_blk][acc_word][acc_pid]) begin
            dlvr_d[acc_blk][acc_pid] = 1'b1;
            for (int wi = 0; wi < NWORD; wi++)
               chg_d[acc_blk][wi][acc_pid] = 1'b0;
         end
         // a store ends every other holder's lifetime
         if (acc_store) begin
            for (int q = 0; q < NPROC; q++) begin
               if (PID_W'(q) != acc_pid && held_q[acc_blk][q]) begin
                  chg_d[acc_blk][acc_word][q] = 1'b1;
                  kind = judge(prior_q[acc_blk][q], dlvr_q[acc_blk][q]);
                  bump[kind] = bump[kind] + INC_W'(1);
                  prior_d[acc_blk][q] = 1'b1;
                  held_d[acc_blk][q]  = 1'b0;
               end
            end
         end
      end else if (sw_fire && held_q[sw_blk][sw_pid]) begin
         kind = judge(prior_q[sw_blk][sw_pid], dlvr_q[sw_blk][sw_pid]);
         bump[kind] = INC_W'(1);
         prior_d[sw_blk][sw_pid] = 1'b1;
         held_d[sw_blk][sw_pid]  = 1'b0;
      end
   end

endmodule

// File: rtl/mcls_sweep.sv
module mcls_sweep #(
   parameter int NPROC = 4,
   parameter int NBLK  = 4,
   localparam int PID_W = $clog2(NPROC),
   localparam int BLK_W = $clog2(NBLK),
   localparam int IDX_W = PID_W + BLK_W,
   localparam int PAIRS = NPROC * NBLK
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             busy,
   output logic [PID_W-1:0] pid,
   output logic [BLK_W-1:0] blk
);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         idx_q <= '0;
      end else if (!busy) begin
         idx_q <= '0;
         if (start)
            busy <= 1'b1;
      end else begin
         idx_q <= idx_q + IDX_W'(1);
         if (idx_q == IDX_W'(PAIRS - 1))
            busy <= 1'b0;
      end
   end

   assign pid = idx_q[PID_W-1:0];
   assign blk = idx_q[IDX_W-1:PID_W];

endmodule

// File: rtl/mcls_counter.sv
module mcls_counter #(
   parameter int CNT_W    = 32,
   parameter int INC_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W:0] sum;

   assign sum = {1'b0, count} + (CNT_W+1)'(inc);

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst)
               count <= '0;
            else if (sum[CNT_W])
               count <= '1;
            else
               count <= sum[CNT_W-1:0];
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst)
               count <= '0;
            else
               count <= sum[CNT_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
   parameter int NPROC    = 4,
   parameter int NBLK     = 4,
   parameter int NWORD    = 4,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1,
   localparam int PID_W = $clog2(NPROC),
   localparam int BLK_W = $clog2(NBLK),
   localparam int WRD_W = $clog2(NWORD),
   localparam int INC_W = $clog2(NPROC) + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_valid,
   output logic             ref_ready,
   input  logic [PID_W-1:0] ref_pid,
   input  logic [BLK_W-1:0] ref_blk,
   input  logic [WRD_W-1:0] ref_word,
   input  logic             ref_store,
   input  logic             end_trace,
   output logic [CNT_W-1:0] cold_count,
   output logic [CNT_W-1:0] true_count,
   output logic [CNT_W-1:0] false_count
);

   generate
      if (NPROC < 2 || (1 << PID_W) != NPROC) begin : g_bad_nproc
         $error("NPROC must be a power of two, at least 2");
      end
      if (NBLK < 2 || (1 << BLK_W) != NBLK) begin : g_bad_nblk
         $error("NBLK must be a power of two, at least 2");
      end
      if (NWORD < 2 || (1 << WRD_W) != NWORD) begin : g_bad_nword
         $error("NWORD must be a power of two, at least 2");
      end
      if (CNT_W <= INC_W) begin : g_bad_cnt
         $error("CNT_W must exceed the per-cycle increment width");
      end
   endgenerate

   logic [NBLK-1:0][NPROC-1:0]            held_q, held_d;
   logic [NBLK-1:0][NPROC-1:0]            dlvr_q, dlvr_d;
   logic [NBLK-1:0][NPROC-1:0]            prior_q, prior_d;
   logic [NBLK-1:0][NWORD-1:0][NPROC-1:0] chg_q, chg_d;
   logic [2:0][INC_W-1:0]                 bump;
   logic [2:0][CNT_W-1:0]                 counts;

   logic             sweep_busy;
   logic [PID_W-1:0] sw_pid;
   logic [BLK_W-1:0] sw_blk;
   logic             acc_fire;

   assign ref_ready = !sweep_busy;
   assign acc_fire  = ref_valid && ref_ready;

   mcls_sweep #(.NPROC(NPROC), .NBLK(NBLK)) i_sweep (
      .clk   (clk),
      .rst   (rst),
      .start (end_trace && !sweep_busy),
      .busy  (sweep_busy),
      .pid   (sw_pid),
      .blk   (sw_blk)
   );

   mcls_flag_update #(.NPROC(NPROC), .NBLK(NBLK), .NWORD(NWORD), .INC_W(INC_W)) i_update (
      .acc_fire  (acc_fire),
      .acc_pid   (ref_pid),
      .acc_blk   (ref_blk),
      .acc_word  (ref_word),
      .acc_store (ref_store),
      .sw_fire   (sweep_busy),
      .sw_pid    (sw_pid),
      .sw_blk    (sw_blk),
      .held_q    (held_q),
      .dlvr_q    (dlvr_q),
      .prior_q   (prior_q),
      .chg_q     (chg_q),
      .held_d    (held_d),
      .dlvr_d    (dlvr_d),
      .prior_d   (prior_d),
      .chg_d     (chg_d),
      .bump      (bump)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q  <= '0;
         dlvr_q  <= '0;
         prior_q <= '0;
         chg_q   <= '0;
      end else begin
         held_q  <= held_d;
         dlvr_q  <= dlvr_d;
         prior_q <= prior_d;
         chg_q   <= chg_d;
      end
   end

   generate
      for (genvar k = 0; k < 3; k++) begin : g_cnt
         mcls_counter #(.CNT_W(CNT_W), .INC_W(INC_W), .SATURATE(SATURATE)) i_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (bump[k]),
            .count (counts[k])
         );
      end
   endgenerate

   assign cold_count  = counts[0];
   assign true_count  = counts[1];
   assign false_count = counts[2];

endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
   parameter int NPROC    = 4,
   parameter int NBLK     = 4,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1,
   localparam int PAIRS = NPROC * NBLK,
   localparam int LOW_W = $clog2(PAIRS + 1) + 1
) (
   input logic             clk,
   input logic             rst,
   input logic             ref_valid,
   input logic             ref_ready,
   input logic             ref_store,
   input logic             end_trace,
   input logic [CNT_W-1:0] cold_count,
   input logic [CNT_W-1:0] true_count,
   input logic [CNT_W-1:0] false_count
);

   logic [LOW_W-1:0] low_cnt;
   logic [CNT_W+1:0] total;

   assign total = {2'b00, cold_count} + {2'b00, true_count} + {2'b00, false_count};

   always_ff @(posedge clk) begin
      if (rst || ref_ready)
         low_cnt <= '0;
      else
         low_cnt <= low_cnt + LOW_W'(1);
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (cold_count == '0 && true_count == '0 && false_count == '0 && ref_ready));

   // R2
   load_no_count_chk: assert property (@(posedge clk) disable iff (rst)
      (ref_valid && ref_ready && !ref_store) |=>
         ($stable(cold_count) && $stable(true_count) && $stable(false_count)));

   // R3
   store_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (ref_valid && ref_ready && ref_store) |=> (total - $past(total) <= (CNT_W+2)'(NPROC - 1)));

   // R7
   sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
      (end_trace && ref_ready) |=> !ref_ready);

   // R7
   sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
      (ref_ready && !$past(ref_ready)) |-> (low_cnt == LOW_W'(PAIRS)));

   generate
      if (SATURATE) begin : g_mono
         // R9
         count_mono_chk: assert property (@(posedge clk) disable iff (rst)
            (cold_count >= $past(cold_count) && true_count >= $past(true_count) &&
             false_count >= $past(false_count)));
      end
   endgenerate

endmodule

bind miss_classifier miss_classifier_chk #(
   .NPROC(NPROC), .NBLK(NBLK), .CNT_W(CNT_W), .SATURATE(SATURATE)
) i_chk (
   .clk         (clk),
   .rst         (rst),
   .ref_valid   (ref_valid),
   .ref_ready   (ref_ready),
   .ref_store   (ref_store),
   .end_trace   (end_trace),
   .cold_count  (cold_count),
   .true_count  (true_count),
   .false_count (false_count)
);

// File: tb/test_miss_classifier.sv
`timescale 1ns/1ps
module test_miss_classifier;

   localparam int NP = 4, NB = 4, NW = 4, CW = 4;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0, rst = 1'b1;
   logic ref_valid = 1'b0, ref_store = 1'b0, end_trace = 1'b0;
   logic [1:0] ref_pid = '0, ref_blk = '0, ref_word = '0;
   logic ref_ready;
   logic [CW-1:0] cold_count, true_count, false_count;

   int checks = 0, failures = 0;

   bit m_held[NB][NP], m_dlvr[NB][NP], m_prior[NB][NP];
   bit m_chg[NB][NW][NP];
   int m_cold, m_true, m_false;

   always #4 clk = ~clk;

   miss_classifier #(.NPROC(NP), .NBLK(NB), .NWORD(NW), .CNT_W(CW), .SATURATE(1'b1)) i_miss_classifier (
      .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_ready(ref_ready),
      .ref_pid(ref_pid), .ref_blk(ref_blk), .ref_word(ref_word), .ref_store(ref_store),
      .end_trace(end_trace), .cold_count(cold_count), .true_count(true_count),
      .false_count(false_count)
   );

   function automatic int sat_inc(input int v);
      return (v < MAXC) ? v + 1 : v;
   endfunction

   task automatic m_clear();
      for (int b = 0; b < NB; b++)
         for (int p = 0; p < NP; p++) begin
            m_held[b][p] = 0; m_dlvr[b][p] = 0; m_prior[b][p] = 0;
            for (int w = 0; w < NW; w++) m_chg[b][w][p] = 0;
         end
      m_cold = 0; m_true = 0; m_false = 0;
   endtask

   task automatic m_end(input int b, input int q);
      if (!m_prior[b][q]) m_cold = sat_inc(m_cold);
      else if (m_dlvr[b][q]) m_true = sat_inc(m_true);
      else m_false = sat_inc(m_false);
      m_prior[b][q] = 1; m_held[b][q] = 0;
   endtask

   task automatic m_apply(input int p, input int b, input int w, input bit st);
      if (!m_held[b][p]) begin m_held[b][p] = 1; m_dlvr[b][p] = 0; end
      if (m_chg[b][w][p]) begin
         m_dlvr[b][p] = 1;
         for (int wi = 0; wi < NW; wi++) m_chg[b][wi][p] = 0;
      end
      if (st)
         for (int q = 0; q < NP; q++)
            if (q != p && m_held[b][q]) begin m_chg[b][w][q] = 1; m_end(b, q); end
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_counts(input string req);
      check({req, " cold"}, int'(cold_count), m_cold);
      check({req, " true"}, int'(true_count), m_true);
      check({req, " false"}, int'(false_count), m_false);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ref_valid = 1'b0; end_trace = 1'b0;
      m_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send(input int p, input int b, input int w, input bit st);
      @(negedge clk);
      ref_valid = 1'b1; ref_pid = 2'(p); ref_blk = 2'(b); ref_word = 2'(w); ref_store = st;
      m_apply(p, b, w, st);
      @(negedge clk);
      ref_valid = 1'b0;
   endtask

   task automatic flush(input string req);
      int low;
      @(negedge clk);
      end_trace = 1'b1;
      @(negedge clk);
      end_trace = 1'b0;
      low = 0;
      check({req, " R7 ready drops"}, int'(ref_ready), 0);
      while (!ref_ready && low < 100) begin
         low++;
         // R8: store offered during the sweep must be ignored
         if (low == 2) begin
            ref_valid = 1'b1; ref_pid = 2'd2; ref_blk = 2'd0; ref_word = 2'd0; ref_store = 1'b1;
         end else ref_valid = 1'b0;
         @(negedge clk);
      end
      ref_valid = 1'b0;
      check({req, " R7 sweep length"}, low, NP * NB);
      for (int b = 0; b < NB; b++)
         for (int p = 0; p < NP; p++)
            if (m_held[b][p]) m_end(b, p);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4242);
      do_reset();
      @(negedge clk);
      // R1
      check("R1 ready", int'(ref_ready), 1);
      check("R1 cold", int'(cold_count), 0);
      check("R1 true", int'(true_count), 0);
      check("R1 false", int'(false_count), 0);

      // directed walk, expected totals worked out by hand
      send(0, 0, 0, 0);
      send(1, 0, 0, 0);
      check("R2 loads add nothing", int'(cold_count + true_count + false_count), 0);
      send(1, 0, 1, 1);
      check("R4 first lifetime is cold", int'(cold_count), 1);
      send(0, 0, 0, 0);
      send(1, 0, 3, 1);
      check("R4 no delivery is false sharing", int'(false_count), 1);
      send(0, 0, 1, 0);
      send(1, 0, 2, 1);
      check("R5 delivered lifetime is true sharing", int'(true_count), 1);
      send(0, 0, 2, 1);
      check("R4 P1 first lifetime ends cold", int'(cold_count), 2);
      send(1, 0, 0, 0);
      send(1, 0, 0, 1);
      check("R6 store delivered data", int'(true_count), 2);
      send(0, 1, 0, 0);
      send(1, 1, 1, 0);
      send(2, 1, 2, 0);
      send(3, 1, 0, 1);
      check("R3 one store ends three lifetimes", int'(cold_count), 5);
      check_counts("R3 model");
      flush("R7");
      check("R7 sweep false", int'(false_count), 2);
      check("R7 sweep cold", int'(cold_count), 6);
      check("R8 ignored store true", int'(true_count), 2);
      check_counts("R8 model");

      // saturation
      do_reset();
      for (int i = 0; i < 20; i++) begin
         send(0, 0, 0, 0);
         send(1, 0, 0, 1);
      end
      check("R9 true saturates", int'(true_count), MAXC);
      check_counts("R9 model");

      // seeded random traffic against the model
      for (int seg = 0; seg < 4; seg++) begin
         do_reset();
         for (int i = 0; i < 60; i++) begin
            send(int'($urandom_range(NP - 1)), int'($urandom_range(1)),
                 int'($urandom_range(NW - 1)), bit'($urandom_range(1)));
            check_counts("R3 R4 R5 random");
         end
         flush("R7 random");
         check_counts("R7 random model");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule